// File: doc/BRIEF.md
# Serial Peripheral FIFO Level and Interrupt Controller

This block sits between the bit-level serial engine of a serial peripheral and the host register interface. It holds a transmit queue that the host fills and the engine drains, and a receive queue that the engine fills and the host drains. Both queues report their fill levels. Each direction has its own programmable threshold. Three sticky error flags record host writes into a full transmit queue, engine pushes into a full receive queue, and host reads from an empty receive queue.

The host sees a five-bit raw interrupt vector and the same vector ANDed with a mask register. It clears the error flags through a write-one-to-clear word. One registered interrupt line is raised while any masked bit is set. A status word gives the full and empty state of each queue and a busy flag passed through from the engine. Queue depth and data width are parameters. Threshold and level widths are derived from the depth.

Top module: `serial_fifo_irq`

## Requirements
- R1: Each queue returns data in first-in first-out order. Its level runs from 0 to DEPTH. A push and a pop in the same cycle leave the level unchanged. A pop from an empty queue has no effect, and an empty queue presents zero on its data output.
- R2: Raw bit 0 (transmit threshold) is 1 exactly while the transmit level is less than or equal to the transmit threshold register.
- R3: Raw bit 4 (receive threshold) is 1 exactly while the receive level is strictly greater than the receive threshold register.
- R4: A host transmit write while the transmit queue is full is dropped. It sets sticky raw bit 1.
- R5: An engine receive push while the receive queue is full is dropped. It sets sticky raw bit 3.
- R6: A host receive read while the receive queue is empty returns zero. It sets sticky raw bit 2.
- R7: Writing the clear word acts as follows: bit 3 clears raw bit 1, bit 2 clears raw bit 3, bit 1 clears raw bit 2, and bit 0 clears all three. The threshold bits are unaffected. An error event in the same cycle as its clear leaves the bit set.
- R8: The masked status equals the raw vector ANDed with the mask register, bit for bit.
- R9: The interrupt output is 1 in the cycle after any masked bit is 1, and 0 in the cycle after the masked status is all zero.
- R10: The status word holds, from bit 4 down to bit 0: receive full (level equals DEPTH), receive empty, transmit empty, transmit full, and the engine busy input.
- R11: After reset, both levels are 0, both thresholds are 0, the mask is 0 and the sticky flags are clear. The raw vector therefore reads 00001, the status reads 01100 with busy low, and the interrupt is 0.
- R12: A register write with address 0 loads the transmit threshold, 1 loads the receive threshold, 2 loads the mask, and 3 applies the clear word. Each takes the low bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_tx_wr | input | 1 | Host pushes a transmit word |
| host_tx_data | input | DW | Transmit word from host |
| host_rx_rd | input | 1 | Host pops a receive word |
| host_rx_data | output | DW | Receive head word (zero when empty) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 tx thr, 1 rx thr, 2 mask, 3 clear) |
| reg_wdata | input | REG_W | Register write data |
| eng_tx_pop | input | 1 | Engine takes a transmit word |
| eng_tx_data | output | DW | Transmit head word (zero when empty) |
| eng_rx_push | input | 1 | Engine delivers a receive word |
| eng_rx_data | input | DW | Receive word from engine |
| eng_busy | input | 1 | Engine busy flag for the status word |
| tx_level | output | LW | Transmit fill level |
| rx_level | output | LW | Receive fill level |
| status_word | output | 5 | Queue and busy status |
| raw_status | output | 5 | Raw interrupt vector |
| irq_status | output | 5 | Masked interrupt vector |
| irq_mask | output | 5 | Mask register readback |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with DEPTH set to 8 and DW set to 8. This gives a three-bit threshold and a four-bit level. With these values both queues reach full within a few cycles, so the overflow, full-status and threshold extremes (a threshold of 7 against a level of 8) are all exercised in a short run. The short queue also makes it cheap to drain a full queue entry by entry and confirm that a dropped word never reappears.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

   localparam int IRQ_W = 5;

   // raw / mask bit positions
   localparam int IRQ_TXE = 0;
   localparam int IRQ_TXO = 1;
   localparam int IRQ_RXU = 2;
   localparam int IRQ_RXO = 3;
   localparam int IRQ_RXF = 4;

   // clear word bit positions
   localparam int CLR_ALL = 0;
   localparam int CLR_RXU = 1;
   localparam int CLR_RXO = 2;
   localparam int CLR_TXO = 3;
   localparam int CLR_W   = 4;

   typedef enum logic [1:0] {
      ADDR_TXWM = 2'd0,
      ADDR_RXWM = 2'd1,
      ADDR_MASK = 2'd2,
      ADDR_CLR  = 2'd3
   } sfi_addr_e;

endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   parameter int AW    = $clog2(DEPTH),
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          push_drop,
   output logic          pop_miss
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfi_fifo: DEPTH must be a power of two of at least 2");
   end
   if (AW != $clog2(DEPTH) || LW != $clog2(DEPTH + 1)) begin : g_bad_width
      $error("sfi_fifo: AW/LW do not match DEPTH");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign full      = (level == LW'(DEPTH));
   assign empty     = (level == '0);
   assign push_ok   = push && !full;
   assign pop_ok    = pop && !empty;
   assign push_drop = push && full;
   assign pop_miss  = pop && empty;
   assign head_data = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   // R1
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   // R1
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !(pop && !empty)) |=> (level == $past(level) + 1'b1));

endmodule

// File: rtl/sfi_irq.sv
module sfi_irq
   import sfi_pkg::*;
#(
   parameter int LW  = 6,
   parameter int WMW = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    tx_level,
   input  logic [LW-1:0]    rx_level,
   input  logic [WMW-1:0]   tx_wm,
   input  logic [WMW-1:0]   rx_wm,
   input  logic             ev_txo,
   input  logic             ev_rxo,
   input  logic             ev_rxu,
   input  logic             clr_wr,
   input  logic [CLR_W-1:0] clr_bits,
   input  logic [IRQ_W-1:0] mask,
   output logic [IRQ_W-1:0] raw,
   output logic [IRQ_W-1:0] masked,
   output logic             irq
);

   if (WMW >= LW) begin : g_bad_wm
      $error("sfi_irq: threshold must be narrower than level");
   end

   localparam int NSTICKY = 3;

   logic [NSTICKY-1:0] ev_vec, clr_hit, sticky;
   logic               txe_hit, rxf_hit;

   // sticky slot 0: tx overflow, 1: rx underflow, 2: rx overflow
   assign ev_vec  = {ev_rxo, ev_rxu, ev_txo};
   assign clr_hit = {clr_bits[CLR_RXO], clr_bits[CLR_RXU], clr_bits[CLR_TXO]}
                    | {NSTICKY{clr_bits[CLR_ALL]}};

   for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
      always_ff @(posedge clk) begin
         if (!rst_n)         sticky[i] <= 1'b0;
         else if (ev_vec[i]) sticky[i] <= 1'b1;
         else if (clr_wr && clr_hit[i]) sticky[i] <= 1'b0;
      end
   end

   assign txe_hit = (tx_level <= LW'(tx_wm));
   assign rxf_hit = (rx_level >  LW'(rx_wm));

   always_comb begin
      raw          = '0;
      raw[IRQ_TXE] = txe_hit;
      raw[IRQ_TXO] = sticky[0];
      raw[IRQ_RXU] = sticky[1];
      raw[IRQ_RXO] = sticky[2];
      raw[IRQ_RXF] = rxf_hit;
   end

   assign masked = raw & mask;

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |masked;
   end

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|masked) |=> irq);

   // R9
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|masked) |=> !irq);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_txo && clr_wr && clr_bits[CLR_ALL]) |=> raw[IRQ_TXO]);

endmodule

// File: rtl/serial_fifo_irq.sv
module serial_fifo_irq
   import sfi_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   parameter int REG_W = 8,
   parameter int WMW   = $clog2(DEPTH),
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_tx_wr,
   input  logic [DW-1:0]    host_tx_data,
   input  logic             host_rx_rd,
   output logic [DW-1:0]    host_rx_data,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             eng_tx_pop,
   output logic [DW-1:0]    eng_tx_data,
   input  logic             eng_rx_push,
   input  logic [DW-1:0]    eng_rx_data,
   input  logic             eng_busy,
   output logic [LW-1:0]    tx_level,
   output logic [LW-1:0]    rx_level,
   output logic [4:0]       status_word,
   output logic [IRQ_W-1:0] raw_status,
   output logic [IRQ_W-1:0] irq_status,
   output logic [IRQ_W-1:0] irq_mask,
   output logic             irq
);

   if (WMW != $clog2(DEPTH) || LW != WMW + 1) begin : g_bad_derived
      $error("serial_fifo_irq: WMW/LW must follow DEPTH");
   end
   if (REG_W < WMW || REG_W < IRQ_W) begin : g_bad_regw
      $error("serial_fifo_irq: REG_W too narrow");
   end

   logic [WMW-1:0] tx_wm, rx_wm;
   logic           tx_full, tx_empty, rx_full, rx_empty;
   logic           tx_drop, rx_drop, rx_miss, tx_miss_unused;
   logic           clr_wr;
   logic           unused_wdata_bits;

   assign unused_wdata_bits = ^reg_wdata;
   assign clr_wr = reg_wr && (reg_addr == ADDR_CLR);

   // register writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_wm    <= '0;
         rx_wm    <= '0;
         irq_mask <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            ADDR_TXWM: tx_wm    <= reg_wdata[WMW-1:0];
            ADDR_RXWM: rx_wm    <= reg_wdata[WMW-1:0];
            ADDR_MASK: irq_mask <= reg_wdata[IRQ_W-1:0];
            default:   ;
         endcase
      end
   end

   sfi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (host_tx_wr),
      .push_data (host_tx_data),
      .pop       (eng_tx_pop),
      .head_data (eng_tx_data),
      .level     (tx_level),
      .full      (tx_full),
      .empty     (tx_empty),
      .push_drop (tx_drop),
      .pop_miss  (tx_miss_unused)
   );

   sfi_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (eng_rx_push),
      .push_data (eng_rx_data),
      .pop       (host_rx_rd),
      .head_data (host_rx_data),
      .level     (rx_level),
      .full      (rx_full),
      .empty     (rx_empty),
      .push_drop (rx_drop),
      .pop_miss  (rx_miss)
   );

   sfi_irq #(.LW(LW), .WMW(WMW)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_wm    (tx_wm),
      .rx_wm    (rx_wm),
      .ev_txo   (tx_drop),
      .ev_rxo   (rx_drop),
      .ev_rxu   (rx_miss),
      .clr_wr   (clr_wr),
      .clr_bits (reg_wdata[CLR_W-1:0]),
      .mask     (irq_mask),
      .raw      (raw_status),
      .masked   (irq_status),
      .irq      (irq)
   );

   assign status_word = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};

   // R4
   tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_wr && tx_level == LW'(DEPTH)) |=> raw_status[IRQ_TXO]);

   // R5
   rx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_level == LW'(DEPTH)) |=> raw_status[IRQ_RXO]);

   // R6
   rx_udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rx_rd && rx_level == '0) |-> (host_rx_data == '0));

   // R7
   clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && reg_wdata[CLR_ALL] && !host_tx_wr && !eng_rx_push && !host_rx_rd)
      |=> (raw_status[3:1] == 3'b000));

endmodule

// File: tb/tb_serial_fifo_irq.sv
module tb_serial_fifo_irq;

   localparam int DEPTH = 8;
   localparam int DW    = 8;
   localparam int LW    = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          host_tx_wr, host_rx_rd, reg_wr, eng_tx_pop, eng_rx_push, eng_busy;
   logic [DW-1:0] host_tx_data, host_rx_data, eng_tx_data, eng_rx_data;
   logic [1:0]    reg_addr;
   logic [7:0]    reg_wdata;
   logic [LW-1:0] tx_level, rx_level;
   logic [4:0]    status_word, raw_status, irq_status, irq_mask;
   logic          irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   serial_fifo_irq #(.DEPTH(DEPTH), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n),
      .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
      .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_busy(eng_busy),
      .tx_level(tx_level), .rx_level(rx_level), .status_word(status_word),
      .raw_status(raw_status), .irq_status(irq_status), .irq_mask(irq_mask),
      .irq(irq)
   );

   // op: 0 host tx write, 1 engine tx pop, 2 engine rx push, 3 host rx read, 4 register write
   typedef struct packed {
      logic [2:0] op;
      logic [1:0] addr;
      logic [7:0] dat;
      logic [3:0] txl;
      logic [3:0] rxl;
      logic [4:0] raw;
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{3'd4, 2'd0, 8'h02, 4'd0, 4'd0, 5'b00001},
      '{3'd0, 2'd0, 8'hA1, 4'd1, 4'd0, 5'b00001},
      '{3'd0, 2'd0, 8'hA2, 4'd2, 4'd0, 5'b00001},
      '{3'd0, 2'd0, 8'hA3, 4'd3, 4'd0, 5'b00000},
      '{3'd1, 2'd0, 8'hA1, 4'd2, 4'd0, 5'b00001},
      '{3'd4, 2'd1, 8'h01, 4'd2, 4'd0, 5'b00001},
      '{3'd2, 2'd0, 8'h5B, 4'd2, 4'd1, 5'b00001},
      '{3'd2, 2'd0, 8'h6C, 4'd2, 4'd2, 5'b10001},
      '{3'd3, 2'd0, 8'h5B, 4'd2, 4'd1, 5'b00001},
      '{3'd3, 2'd0, 8'h6C, 4'd2, 4'd0, 5'b00001},
      '{3'd3, 2'd0, 8'h00, 4'd2, 4'd0, 5'b00101},
      '{3'd4, 2'd3, 8'h02, 4'd2, 4'd0, 5'b00001}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      host_tx_wr = 0; host_rx_rd = 0; reg_wr = 0; eng_tx_pop = 0; eng_rx_push = 0;
   endtask

   task automatic do_reset();
      idle();
      eng_busy = 0; host_tx_data = '0; eng_rx_data = '0; reg_addr = '0; reg_wdata = '0;
      rst_n = 0;
      cyc(); cyc();
      rst_n = 1;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wr = 0;
   endtask

   task automatic tx_push(input logic [7:0] d);
      host_tx_wr = 1; host_tx_data = d;
      cyc();
      host_tx_wr = 0;
   endtask

   task automatic rx_push(input logic [7:0] d);
      eng_rx_push = 1; eng_rx_data = d;
      cyc();
      eng_rx_push = 0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R11 reset state
      chk("R11 tx_level", int'(tx_level), 0);
      chk("R11 rx_level", int'(rx_level), 0);
      chk("R11 raw", int'(raw_status), 5'b00001);
      chk("R11 status R10", int'(status_word), 5'b01100);
      chk("R11 mask", int'(irq_mask), 0);
      chk("R11 irq", int'(irq), 0);

      // table walk: R1 R2 R3 R6 R7 R12
      foreach (TBL[i]) begin
         case (TBL[i].op)
            3'd0: tx_push(TBL[i].dat);
            3'd1: begin
               eng_tx_pop = 1; #1;
               chk("R1 tx head order", int'(eng_tx_data), int'(TBL[i].dat));
               cyc(); eng_tx_pop = 0;
            end
            3'd2: rx_push(TBL[i].dat);
            3'd3: begin
               host_rx_rd = 1; #1;
               chk("R1/R6 rx read data", int'(host_rx_data), int'(TBL[i].dat));
               cyc(); host_rx_rd = 0;
            end
            default: wr_reg(TBL[i].addr, TBL[i].dat);
         endcase
         chk($sformatf("R12 vec%0d tx_level", i), int'(tx_level), int'(TBL[i].txl));
         chk($sformatf("R1 vec%0d rx_level", i), int'(rx_level), int'(TBL[i].rxl));
         chk($sformatf("R2/R3/R7 vec%0d raw", i), int'(raw_status), int'(TBL[i].raw));
      end

      // transmit fill, overflow, drain
      do_reset();
      for (int k = 0; k < DEPTH; k++) tx_push(8'h10 + 8'(k));
      chk("R1 tx full level", int'(tx_level), DEPTH);
      chk("R10 tx full status", int'(status_word[1]), 1);
      chk("R2 tx thr at full", int'(raw_status[0]), 0);
      tx_push(8'hEE);
      chk("R4 tx level after drop", int'(tx_level), DEPTH);
      chk("R4 tx overflow flag", int'(raw_status[1]), 1);
      for (int k = 0; k < DEPTH; k++) begin
         eng_tx_pop = 1; #1;
         chk("R4 R1 drain order", int'(eng_tx_data), 8'h10 + k);
         cyc();
      end
      eng_tx_pop = 1; #1;
      chk("R1 empty head zero", int'(eng_tx_data), 0);
      cyc(); eng_tx_pop = 0;
      chk("R1 pop empty level", int'(tx_level), 0);
      chk("R10 tx empty status", int'(status_word[2]), 1);

      // receive overflow and underflow
      for (int k = 0; k < DEPTH + 1; k++) rx_push(8'h20 + 8'(k));
      chk("R5 rx level after drop", int'(rx_level), DEPTH);
      chk("R5 rx overflow flag", int'(raw_status[3]), 1);
      chk("R10 rx full status", int'(status_word[4]), 1);
      for (int k = 0; k < DEPTH; k++) begin
         host_rx_rd = 1; #1;
         chk("R5 rx drain order", int'(host_rx_data), 8'h20 + k);
         cyc();
      end
      host_rx_rd = 1; #1;
      chk("R6 empty read zero", int'(host_rx_data), 0);
      cyc(); host_rx_rd = 0;
      chk("R6 rx underflow flag", int'(raw_status[2]), 1);
      chk("R7 all sticky set", int'(raw_status), 5'b01111);

      // selective clears
      wr_reg(2'd3, 8'h08);
      chk("R7 clr bit3 tx ovf", int'(raw_status), 5'b01101);
      wr_reg(2'd3, 8'h04);
      chk("R7 clr bit2 rx ovf", int'(raw_status), 5'b00101);
      tx_push(8'h01);
      for (int k = 0; k < DEPTH; k++) rx_push(8'h30);
      rx_push(8'h31);
      for (int k = 0; k < DEPTH - 1; k++) tx_push(8'h02);
      tx_push(8'h03);
      chk("R7 set again", int'(raw_status[3:1]), 3'b111);
      wr_reg(2'd3, 8'h01);
      chk("R7 clr bit0 all", int'(raw_status[3:1]), 3'b000);

      // clear and event in same cycle: event wins
      host_tx_wr = 1; host_tx_data = 8'h44;
      reg_wr = 1; reg_addr = 2'd3; reg_wdata = 8'h08;
      cyc(); idle();
      chk("R7 set wins over clear", int'(raw_status[1]), 1);
      wr_reg(2'd3, 8'h08);
      chk("R7 cleared after", int'(raw_status[1]), 0);

      // receive threshold boundary (rx full of 8, thr 7 -> 8>7)
      wr_reg(2'd1, 8'h07);
      chk("R3 level 8 thr 7", int'(raw_status[4]), 1);
      host_rx_rd = 1; cyc(); host_rx_rd = 0;
      chk("R3 level 7 thr 7", int'(raw_status[4]), 0);

      // mask and interrupt timing; tx is full (8), thr 0
      wr_reg(2'd2, 8'h01);
      chk("R12 mask readback", int'(irq_mask), 1);
      chk("R8 masked zero", int'(irq_status), 0);
      chk("R9 irq low", int'(irq), 0);
      wr_reg(2'd0, 8'h07);
      eng_tx_pop = 1; cyc(); eng_tx_pop = 0;
      chk("R2 level 7 thr 7", int'(raw_status[0]), 1);
      chk("R8 masked follows raw", int'(irq_status), 5'b00001);
      chk("R9 irq not yet", int'(irq), 0);
      cyc();
      chk("R9 irq one clock later", int'(irq), 1);
      tx_push(8'h55);
      chk("R8 masked drops", int'(irq_status), 0);
      chk("R9 irq still high", int'(irq), 1);
      cyc();
      chk("R9 irq falls", int'(irq), 0);
      wr_reg(2'd2, 8'h10);
      chk("R8 mask other bit", int'(irq_status), 5'b00000);

      // busy passthrough
      eng_busy = 1; #1;
      chk("R10 busy bit", int'(status_word[0]), 1);
      eng_busy = 0; #1;
      chk("R10 busy low", int'(status_word[0]), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule